// File: doc/BRIEF.md
# Time-Shared Eigendecomposition Sequencer

This block is the central sequencer for an eigendecomposition array that has been folded onto one shared complex CORDIC unit. Input data is written into a staging buffer while `load_en` is high. The sequencer treats the falling edge of `load_en` as the start command.

On that edge it switches to the other input bank and pulses a datapath reset for one cycle. It then walks the triangular schedule one cell at a time. Each row of the schedule opens with a vectoring operation on its diagonal cell and continues with rotation operations on the cells to its right, up to and including the extra right-hand column. Every operation occupies a fixed number of cycles, which is the CORDIC latency. The sequencer pulses `start` at the beginning of an operation and `wr_en` in its final cycle. Read and write addresses are 6-bit words that hold the row and the column. Each address points at one 32-bit complex data word.

Results of successive passes go alternately to an even output bank and an odd output bank. A processor can therefore read the finished pass while the next one is written. At the end of a pass `done` rises and stays high, acting as an interrupt, until software pulses `done_clr`.

Top module: `evd_sequencer`

## Requirements
- R1: During reset and on the first cycle after it, all of these outputs read 0: `busy`, `done`, `in_bank`, `out_bank`, `start`, `wr_en`, `dp_rst`, `cordic_ce`, `rd_addr`.
- R2: While `load_en` is high the block loads only. `busy`, `start` and `dp_rst` stay 0. Processing is triggered by the first clock edge that sees `load_en` low after a load.
- R3: On the cycle after that edge, `dp_rst` is high for exactly one cycle and `busy` is high. At the same point `in_bank` inverts, once per pass.
- R4: Processing then runs operations back to back, with N=4 rows and LAT=16 cycles per operation. Row r (0..N-1) covers columns c=r..N in order. `rd_addr` holds r in bits [5:3] and c in bits [2:0] for the whole operation. `start` is high only in its first cycle.
- R5: `vec_mode` is 1 during every operation whose column equals its row, which is the first cell of each row. It is 0 during all other operations.
- R6: `wr_en` is high only in the last cycle of each operation. `wr_addr` then equals that operation's address.
- R7: One cycle after the last write, `busy` falls and `done` rises. `done` remains 1 until a cycle in which `done_clr` is high, and reads 0 after that cycle.
- R8: `out_bank` inverts on the cycle `done` is set and holds its value throughout a pass. Consecutive passes therefore write opposite output banks.
- R9: `cordic_ce` is 1 in the first busy cycle, alternates every cycle while `busy` is high, and is 0 whenever `busy` is low.
- R10: Changes of `load_en` while `busy` is high have no effect. The schedule, its timing and `in_bank` are unchanged.
- R11: A new load and pass may begin while `done` is still set. The pass leaves `done` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | High while the input buffer is being loaded; its fall starts a pass |
| done_clr | input | 1 | Clears the done flag |
| in_bank | output | 1 | Input bank currently read by the array |
| vec_mode | output | 1 | 1 = vectoring, 0 = rotation for the shared CORDIC |
| start | output | 1 | First cycle of a CORDIC operation |
| rd_addr | output | 6 | Operand address {row, column} |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 6 | Result address {row, column} |
| out_bank | output | 1 | Output bank being written by the current pass |
| cordic_ce | output | 1 | Half-rate CORDIC clock enable |
| dp_rst | output | 1 | One-cycle datapath reset at pass start |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Sticky completion flag, used as an interrupt |

## Verification
A faulty row or column counter shows up at the very next operation boundary as a wrong `rd_addr`, a misplaced `vec_mode`, or a total pass length different from 224 cycles. The bench compares every cycle of every pass against a schedule it computes arithmetically, so such a fault is reported within one operation. A wrong bank toggle or a lost done flag only becomes visible at pass boundaries. For that reason three passes are run, one of them with `load_en` noise during processing and one started while `done` is still set.

// File: rtl/evd_sequencer.sv
module evd_sequencer #(
  parameter int N   = 4,
  parameter int LAT = 16,
  parameter int AW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          done_clr,
  output logic          in_bank,
  output logic          vec_mode,
  output logic          start,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          out_bank,
  output logic          cordic_ce,
  output logic          dp_rst,
  output logic          busy,
  output logic          done
);
  localparam int CW = AW / 2;
  localparam int TW = (LAT > 2) ? $clog2(LAT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_CLR, S_RUN} st_t;
  st_t st, nx;

  logic [CW-1:0] row, col;
  logic [TW-1:0] tc;
  logic          op_last, row_last, pass_end, run;

  assign run      = (st == S_RUN);
  assign op_last  = (tc == TW'(LAT - 1));
  assign row_last = (col == CW'(N));
  assign pass_end = run && op_last && row_last && (row == CW'(N - 1));

  always_comb begin
    nx = st;
    case (st)
      S_IDLE: if (load_en) nx = S_LOAD;
      S_LOAD: if (!load_en) nx = S_CLR;
      S_CLR:  nx = S_RUN;
      S_RUN:  if (pass_end) nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      row       <= '0;
      col       <= '0;
      tc        <= '0;
      in_bank   <= 1'b0;
      out_bank  <= 1'b0;
      done      <= 1'b0;
      cordic_ce <= 1'b0;
    end else begin
      st        <= nx;
      cordic_ce <= (nx == S_CLR || nx == S_RUN) ? ~cordic_ce : 1'b0;
      if (st == S_LOAD && !load_en) in_bank <= ~in_bank;
      if (st == S_CLR) begin
        row <= '0;
        col <= '0;
        tc  <= '0;
      end else if (run) begin
        tc <= op_last ? '0 : tc + TW'(1);
        if (op_last) begin
          if (row_last) begin
            row <= row + CW'(1);
            col <= row + CW'(1);
          end else begin
            col <= col + CW'(1);
          end
        end
      end
      if (pass_end) begin
        done     <= 1'b1;
        out_bank <= ~out_bank;
      end else if (done_clr) begin
        done <= 1'b0;
      end
    end
  end

  assign busy     = (st == S_CLR) || run;
  assign dp_rst   = (st == S_CLR);
  assign start    = run && (tc == '0);
  assign vec_mode = run && (col == row);
  assign rd_addr  = run ? {row, col} : '0;
  assign wr_en    = run && op_last;
  assign wr_addr  = wr_en ? {row, col} : '0;
endmodule

// File: rtl/evd_sequencer_chk.sv
module evd_sequencer_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_en,
  input logic          done_clr,
  input logic          in_bank,
  input logic          vec_mode,
  input logic          start,
  input logic [AW-1:0] rd_addr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          out_bank,
  input logic          cordic_ce,
  input logic          dp_rst,
  input logic          busy,
  input logic          done
);
  localparam int CW = AW / 2;

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cordic_ce && !start && !wr_en));
  assert_ce_alternates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cordic_ce) |=> !cordic_ce);
  assert_clear_then_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rst |=> (start && vec_mode && !dp_rst));
  assert_bank_flip_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_rst) |-> (in_bank != $past(in_bank)));
  assert_vector_on_diagonal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vec_mode) |-> (rd_addr[AW-1:CW] == rd_addr[CW-1:0]));
  assert_write_matches_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr == rd_addr));
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);
  assert_outbank_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(out_bank));
  assert_done_flips_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (done && out_bank != $past(out_bank)));
endmodule

bind evd_sequencer evd_sequencer_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_evd_sequencer.sv
`timescale 1ns/1ps
module tb_evd_sequencer;
  localparam int N   = 4;
  localparam int LAT = 16;
  localparam int TOT = N * (N + 1) / 2 + N;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic       done_clr = 1'b0;
  logic       in_bank, vec_mode, start, wr_en, out_bank, cordic_ce, dp_rst, busy, done;
  logic [5:0] rd_addr, wr_addr;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  evd_sequencer #(.N(N), .LAT(LAT), .AW(6)) dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .done_clr(done_clr),
    .in_bank(in_bank), .vec_mode(vec_mode), .start(start), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .out_bank(out_bank), .cordic_ce(cordic_ce),
    .dp_rst(dp_rst), .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int op_addr(input int idx);
    int k = idx;
    for (int r = 0; r < N; r++) begin
      if (k < N - r + 1) return r * 8 + r + k;
      k -= N - r + 1;
    end
    return -1;
  endfunction

  task automatic run_pass(input int hold, input bit noisy, input int exp_in,
                          input int exp_out, input int done_before);
    @(negedge clk);
    load_en = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R2 busy while loading", busy, 0);
      check("R2 dp_rst while loading", dp_rst, 0);
      check("R2 start while loading", start, 0);
    end
    load_en = 1'b0;
    for (int n = 1; n <= 2 + TOT * LAT; n++) begin
      @(negedge clk);
      if (n == 1) begin
        check("R3 dp_rst pulse", dp_rst, 1);
        check("R3 busy", busy, 1);
        check("R3 in_bank", in_bank, exp_in);
        check("R9 first ce", cordic_ce, 1);
        check("R4 no start in clear cycle", start, 0);
      end else if (n <= 1 + TOT * LAT) begin
        int m  = n - 2;
        int ph = m % LAT;
        int a  = op_addr(m / LAT);
        check("R3 dp_rst single", dp_rst, 0);
        check("R4 start", start, (ph == 0) ? 1 : 0);
        check("R4 rd_addr", rd_addr, a);
        check("R5 vec_mode", vec_mode, ((a >> 3) == (a & 7)) ? 1 : 0);
        check("R6 wr_en", wr_en, (ph == LAT - 1) ? 1 : 0);
        if (ph == LAT - 1) check("R6 wr_addr", wr_addr, a);
        check("R9 ce", cordic_ce, ((n - 1) % 2 == 0) ? 1 : 0);
        check("R10 in_bank held", in_bank, exp_in);
        check("R8 out_bank held", out_bank, exp_out);
        check("R11 done during pass", done, done_before);
        check("R7 busy", busy, 1);
      end else begin
        check("R7 busy falls", busy, 0);
        check("R7 done rises", done, 1);
        check("R8 out_bank flips", out_bank, 1 - exp_out);
        check("R9 ce idle", cordic_ce, 0);
        check("R6 no write", wr_en, 0);
      end
      if (noisy) load_en = (n < TOT * LAT - 4) && (n % 7 == 3);
    end
    load_en = 1'b0;
  endtask

  task automatic clear_done();
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    check("R7 done cleared", done, 0);
  endtask

  initial begin
    #1;
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 in_bank", in_bank, 0);
    check("R1 out_bank", out_bank, 0);
    check("R1 start", start, 0);
    check("R1 wr_en", wr_en, 0);
    check("R1 dp_rst", dp_rst, 0);
    check("R1 cordic_ce", cordic_ce, 0);
    check("R1 rd_addr", rd_addr, 0);

    run_pass(3, 1'b0, 1, 0, 0);
    repeat (5) begin
      @(negedge clk);
      check("R7 done sticky", done, 1);
      check("R7 stays idle", busy, 0);
    end
    clear_done();

    run_pass(1, 1'b1, 0, 1, 0);
    @(negedge clk);
    check("R10 no extra pass", busy, 0);
    check("R10 no extra write", wr_en, 0);

    run_pass(5, 1'b0, 1, 0, 1);
    @(negedge clk);
    check("R11 done still set", done, 1);
    clear_done();
    repeat (3) @(negedge clk);
    check("R7 done remains clear", done, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule